// File: doc/BRIEF.md
# Filtered Overvoltage Fault Latch

This block guards a gate-driver stage against two kinds of short to the battery rail. The first is an overvoltage on the logic supply. The second is an overvoltage on any pin of a group of nine digital I/O pins. A digital comparator output flags each condition, and each condition passes through a persistence filter of its own. When a comparator has stayed high for the programmed number of clock cycles, the block sets a sticky fault flag. While either flag is set, a registered forced-sink command tells every gate driver to discharge its gate at maximum current. In the same state, the discharge-strength setting sent to the drivers is forced to its strongest code, whatever value software has programmed.

A flag is removed only by a read-and-clear request from the serial register interface. The request carries one select bit per flag, and it returns the selected flags as they stood before the clear. A clear is refused unless that flag's comparator has been filtered low, meaning it has stayed low for the same number of cycles. Standby mode resets the whole block, just as the synchronous reset does. All comparator inputs are taken to be synchronous to `clk`.

Top module: `ovp_fault_latch`

## Requirements
- R1: While `rst` or `standby` is high, at the next clock edge `flags`, `rc_data`, `force_sink` and `drive_slew` become zero and all filter progress is lost. A high run that started before standby counts again from zero afterwards.
- R2: A flag sets on the clock edge that follows FILT_CYC consecutive edges at which its comparator was sampled high. A high run of FILT_CYC-1 samples or fewer sets nothing.
- R3: A single low sample inside a high run restarts the count, so two runs that are each shorter than FILT_CYC never set the flag.
- R4: `flags[0]` is the supply overvoltage flag, driven by `vdd_ov_cmp`. `flags[1]` is the I/O overvoltage flag, driven by the OR of all nine bits of `dio_ov_cmp`, so every pin alone can set it.
- R5: A set flag stays set after its comparator returns low, until an accepted clear removes it.
- R6: `force_sink` equals the OR of `flags` one clock later.
- R7: `drive_slew` equals all ones one clock after any flag is set, and equals `slew_cfg` one clock later when no flag is set.
- R8: When `rc_strobe` is high with `rc_sel[i]` high, flag i clears at that edge only if its comparator was sampled low on the FILT_CYC edges before it. Otherwise the flag stays set, and a flag whose select bit is low is never touched.
- R9: On an edge with `rc_strobe` high, `rc_data` takes `flags & rc_sel` as they were before that edge's clear. Without a strobe, `rc_data` holds its value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| standby | input | 1 | Device in standby; resets all state |
| vdd_ov_cmp | input | 1 | Logic-supply overvoltage comparator |
| dio_ov_cmp | input | N_DIO | Per-pin I/O overvoltage comparators |
| rc_strobe | input | 1 | Read-and-clear request |
| rc_sel | input | 2 | Flags selected by the request (bit0 supply, bit1 I/O) |
| slew_cfg | input | SLEW_W | Programmed gate discharge strength |
| flags | output | 2 | Sticky fault flags (bit0 supply, bit1 I/O) |
| rc_data | output | 2 | Flags returned by the last read-and-clear |
| force_sink | output | 1 | Forced maximum-current turn-off command |
| drive_slew | output | SLEW_W | Discharge strength sent to the drivers |

## Verification
A read-and-clear can land on the same edge at which a flag's absence filter completes, and the outcome depends on which side of that edge the request falls. The bench releases the comparator and then raises the strobe so that it is sampled at the FILT_CYC-th low edge, where the clear must be refused. It holds the strobe for one more edge, where the clear must be accepted, and compares `flags` after each of those edges. A second case issues one strobe that selects both flags while only one of them is filtered absent. That strobe must clear one flag, refuse the other, and return both pre-clear values in `rc_data`.

// File: rtl/ovp_pkg.sv
package ovp_pkg;
  // Number of monitored overvoltage sources and their flag positions.
  localparam int N_SRC   = 2;
  localparam int IDX_VDD = 0;
  localparam int IDX_DIO = 1;

  // Counter width large enough to hold a filter limit.
  function automatic int cnt_width(input int limit);
    return (limit < 1) ? 1 : $clog2(limit + 1);
  endfunction
endpackage

// File: rtl/ov_persist_filter.sv
// Persistence filter: counts consecutive equal samples of a comparator and
// reports when the input has been steadily high or steadily low for LIMIT.
module ov_persist_filter #(
  parameter int FILT_CYC = 32
) (
  input  logic clk,
  input  logic rst,
  input  logic raw,
  output logic present_ok,
  output logic absent_ok
);
  localparam int CW = ovp_pkg::cnt_width(FILT_CYC);
  localparam logic [CW-1:0] LIMIT = CW'(FILT_CYC);

  logic          lvl_q;
  logic [CW-1:0] run_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      lvl_q <= 1'b0;
      run_q <= '0;
    end else if (raw != lvl_q) begin
      lvl_q <= raw;
      run_q <= CW'(1);
    end else if (run_q != LIMIT) begin
      run_q <= run_q + CW'(1);
    end
  end

  assign present_ok = lvl_q  && (run_q == LIMIT);
  assign absent_ok  = !lvl_q && (run_q == LIMIT);
endmodule

// File: rtl/ov_flag_cell.sv
// Sticky fault flag: set by a qualified fault, cleared only on request
// and only while the fault is qualified absent.
module ov_flag_cell (
  input  logic clk,
  input  logic rst,
  input  logic present_ok,
  input  logic absent_ok,
  input  logic clr_req,
  output logic flag
);
  always_ff @(posedge clk) begin
    if (rst) begin
      flag <= 1'b0;
    end else if (present_ok) begin
      flag <= 1'b1;
    end else if (clr_req && absent_ok) begin
      flag <= 1'b0;
    end
  end
endmodule

// File: rtl/ov_out_stage.sv
// Registered driver command and read-back capture.
module ov_out_stage #(
  parameter int N_FLAG = 2,
  parameter int SLEW_W = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [N_FLAG-1:0] flags,
  input  logic              rc_strobe,
  input  logic [N_FLAG-1:0] rc_sel,
  input  logic [SLEW_W-1:0] slew_cfg,
  output logic              force_sink,
  output logic [SLEW_W-1:0] drive_slew,
  output logic [N_FLAG-1:0] rc_data
);
  logic any_flag;
  assign any_flag = |flags;

  always_ff @(posedge clk) begin
    if (rst) begin
      force_sink <= 1'b0;
      drive_slew <= '0;
      rc_data    <= '0;
    end else begin
      force_sink <= any_flag;
      drive_slew <= any_flag ? {SLEW_W{1'b1}} : slew_cfg;
      if (rc_strobe) begin
        rc_data <= flags & rc_sel;
      end
    end
  end
endmodule

// File: rtl/ovp_fault_latch.sv
module ovp_fault_latch
  import ovp_pkg::*;
#(
  parameter int FILT_CYC = 32,
  parameter int N_DIO    = 9,
  parameter int SLEW_W   = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              standby,
  input  logic              vdd_ov_cmp,
  input  logic [N_DIO-1:0]  dio_ov_cmp,
  input  logic              rc_strobe,
  input  logic [N_SRC-1:0]  rc_sel,
  input  logic [SLEW_W-1:0] slew_cfg,
  output logic [N_SRC-1:0]  flags,
  output logic [N_SRC-1:0]  rc_data,
  output logic              force_sink,
  output logic [SLEW_W-1:0] drive_slew
);
  logic             state_clr;
  logic [N_SRC-1:0] raw_ov;
  logic [N_SRC-1:0] present_ok;
  logic [N_SRC-1:0] absent_ok;

  assign state_clr       = rst || standby;
  assign raw_ov[IDX_VDD] = vdd_ov_cmp;
  assign raw_ov[IDX_DIO] = |dio_ov_cmp;

  for (genvar s = 0; s < N_SRC; s++) begin : g_src
    ov_persist_filter #(
      .FILT_CYC(FILT_CYC)
    ) u_filt (
      .clk       (clk),
      .rst       (state_clr),
      .raw       (raw_ov[s]),
      .present_ok(present_ok[s]),
      .absent_ok (absent_ok[s])
    );

    ov_flag_cell u_flag (
      .clk       (clk),
      .rst       (state_clr),
      .present_ok(present_ok[s]),
      .absent_ok (absent_ok[s]),
      .clr_req   (rc_strobe && rc_sel[s]),
      .flag      (flags[s])
    );
  end

  ov_out_stage #(
    .N_FLAG(N_SRC),
    .SLEW_W(SLEW_W)
  ) u_out (
    .clk       (clk),
    .rst       (state_clr),
    .flags     (flags),
    .rc_strobe (rc_strobe),
    .rc_sel    (rc_sel),
    .slew_cfg  (slew_cfg),
    .force_sink(force_sink),
    .drive_slew(drive_slew),
    .rc_data   (rc_data)
  );
endmodule

// File: rtl/ovp_fault_latch_chk.sv
module ovp_fault_latch_chk #(
  parameter int FILT_CYC = 32,
  parameter int N_DIO    = 9,
  parameter int SLEW_W   = 3
) (
  input logic              clk,
  input logic              rst,
  input logic              standby,
  input logic              vdd_ov_cmp,
  input logic [N_DIO-1:0]  dio_ov_cmp,
  input logic              rc_strobe,
  input logic [1:0]        rc_sel,
  input logic [SLEW_W-1:0] slew_cfg,
  input logic [1:0]        flags,
  input logic [1:0]        rc_data,
  input logic              force_sink,
  input logic [SLEW_W-1:0] drive_slew
);
  localparam int CW = ovp_pkg::cnt_width(FILT_CYC);
  localparam logic [CW-1:0] LIM = CW'(FILT_CYC);

  // Independent run-length counters of high and low comparator samples.
  logic [1:0]    cmp;
  logic [CW-1:0] hi_run [2];
  logic [CW-1:0] lo_run [2];
  logic          clr_any;

  assign cmp     = {|dio_ov_cmp, vdd_ov_cmp};
  assign clr_any = rst || standby;

  for (genvar s = 0; s < 2; s++) begin : g_run
    always_ff @(posedge clk) begin
      if (clr_any) begin
        hi_run[s] <= '0;
        lo_run[s] <= '0;
      end else begin
        hi_run[s] <= !cmp[s] ? '0 : ((hi_run[s] == LIM) ? LIM : hi_run[s] + CW'(1));
        lo_run[s] <=  cmp[s] ? '0 : ((lo_run[s] == LIM) ? LIM : lo_run[s] + CW'(1));
      end
    end
  end

  AST_VDD_SET_FILTERED: assert property (@(posedge clk) disable iff (clr_any)
    $rose(flags[0]) |-> $past(hi_run[0]) == LIM); // R2
  AST_DIO_SET_FILTERED: assert property (@(posedge clk) disable iff (clr_any)
    $rose(flags[1]) |-> $past(hi_run[1]) == LIM); // R4
  AST_VDD_CLEAR_GATED: assert property (@(posedge clk) disable iff (clr_any)
    $fell(flags[0]) && !$past(clr_any) |-> $past(rc_strobe && rc_sel[0]) && $past(lo_run[0]) == LIM); // R8
  AST_DIO_CLEAR_GATED: assert property (@(posedge clk) disable iff (clr_any)
    $fell(flags[1]) && !$past(clr_any) |-> $past(rc_strobe && rc_sel[1]) && $past(lo_run[1]) == LIM); // R8
  AST_SINK_TRACKS_FLAGS: assert property (@(posedge clk) disable iff (clr_any)
    !$past(clr_any) |-> force_sink == $past(|flags)); // R6
  AST_SINK_MAX_SLEW: assert property (@(posedge clk) disable iff (clr_any)
    force_sink |-> drive_slew == {SLEW_W{1'b1}}); // R7
  AST_READBACK_HOLD: assert property (@(posedge clk) disable iff (clr_any)
    !$past(rc_strobe) && !$past(clr_any) |-> $stable(rc_data)); // R9
endmodule

bind ovp_fault_latch ovp_fault_latch_chk #(
  .FILT_CYC(FILT_CYC),
  .N_DIO   (N_DIO),
  .SLEW_W  (SLEW_W)
) u_chk (
  .clk       (clk),
  .rst       (rst),
  .standby   (standby),
  .vdd_ov_cmp(vdd_ov_cmp),
  .dio_ov_cmp(dio_ov_cmp),
  .rc_strobe (rc_strobe),
  .rc_sel    (rc_sel),
  .slew_cfg  (slew_cfg),
  .flags     (flags),
  .rc_data   (rc_data),
  .force_sink(force_sink),
  .drive_slew(drive_slew)
);

// File: tb/ovp_fault_latch_tb.sv
`timescale 1ns/1ps
module ovp_fault_latch_tb;
  localparam int F  = 5;
  localparam int ND = 9;
  localparam int SW = 3;

  logic          clk = 1'b0;
  logic          rst, standby, vdd_ov_cmp, rc_strobe;
  logic [ND-1:0] dio_ov_cmp;
  logic [1:0]    rc_sel, flags, rc_data;
  logic [SW-1:0] slew_cfg, drive_slew;
  logic          force_sink;
  int            n_chk = 0;
  int            n_bad = 0;
  bit            done  = 1'b0;

  always #10 clk = ~clk;

  ovp_fault_latch #(.FILT_CYC(F), .N_DIO(ND), .SLEW_W(SW)) u_dut (
    .clk(clk), .rst(rst), .standby(standby), .vdd_ov_cmp(vdd_ov_cmp),
    .dio_ov_cmp(dio_ov_cmp), .rc_strobe(rc_strobe), .rc_sel(rc_sel),
    .slew_cfg(slew_cfg), .flags(flags), .rc_data(rc_data),
    .force_sink(force_sink), .drive_slew(drive_slew)
  );

  // Vector: [9:6] source (0 supply, 1..9 I/O pin index+1), [5:1] high length, [0] flag expected.
  localparam logic [9:0] VEC [8] = '{
    {4'd0, 5'd4,  1'b0}, {4'd0, 5'd5, 1'b1}, {4'd1, 5'd5, 1'b1}, {4'd9, 5'd9, 1'b1},
    {4'd5, 5'd3,  1'b0}, {4'd0, 5'd12, 1'b1}, {4'd3, 5'd4, 1'b0}, {4'd8, 5'd6, 1'b1}
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic drive_src(input int src, input logic v);
    if (src == 0) vdd_ov_cmp = v;
    else dio_ov_cmp[src-1] = v;
  endtask

  task automatic strobe(input logic [1:0] sel);
    rc_strobe = 1'b1; rc_sel = sel;
    tick(1);
    rc_strobe = 1'b0; rc_sel = 2'b00;
  endtask

  initial begin
    rst = 1'b1; standby = 1'b0; vdd_ov_cmp = 1'b0; dio_ov_cmp = '0;
    rc_strobe = 1'b0; rc_sel = 2'b00; slew_cfg = 3'b010;
    tick(3);
    check("R1 reset flags", flags, 2'b00);
    check("R1 reset force_sink", force_sink, 1'b0);
    check("R1 reset rc_data", rc_data, 2'b00);
    check("R1 reset drive_slew", drive_slew, 3'b000);
    rst = 1'b0;
    tick(1);
    check("R7 slew passthrough", drive_slew, 3'b010);

    // Table walk: R2 length threshold, R4 pin mapping, R5 stickiness, R8/R9 clear.
    for (int i = 0; i < 8; i++) begin
      automatic int          src = int'(VEC[i][9:6]);
      automatic int          len = int'(VEC[i][5:1]);
      automatic logic        ex  = VEC[i][0];
      automatic logic [1:0]  msk = ex ? ((src == 0) ? 2'b01 : 2'b10) : 2'b00;
      drive_src(src, 1'b1);
      tick(len);
      drive_src(src, 1'b0);
      tick(3);
      check($sformatf("R2 R4 R5 flags vec%0d", i), flags, msk);
      check($sformatf("R6 force vec%0d", i), force_sink, ex);
      check($sformatf("R7 slew vec%0d", i), drive_slew, ex ? 3'b111 : 3'b010);
      tick(F);
      strobe(2'b11);
      check($sformatf("R9 readback vec%0d", i), rc_data, msk);
      check($sformatf("R8 cleared vec%0d", i), flags, 2'b00);
      tick(1);
      check($sformatf("R6 force released vec%0d", i), force_sink, 1'b0);
    end

    // R3: glitch restarts the run.
    vdd_ov_cmp = 1'b1; tick(3); vdd_ov_cmp = 1'b0; tick(1);
    vdd_ov_cmp = 1'b1; tick(3); vdd_ov_cmp = 1'b0; tick(3);
    check("R3 glitch restart", flags, 2'b00);
    tick(F + 1);

    // R8: refused while fault still present; R7 slew held at max despite cfg change.
    vdd_ov_cmp = 1'b1; tick(F + 2);
    check("R2 set", flags, 2'b01);
    slew_cfg = 3'b001; tick(1);
    check("R7 override ignores cfg", drive_slew, 3'b111);
    strobe(2'b01);
    check("R9 readback present", rc_data, 2'b01);
    check("R8 refused present", flags, 2'b01);
    tick(2);
    check("R9 rc_data holds", rc_data, 2'b01);

    // R8 boundary: strobe at Fth low edge refused, at F+1 accepted.
    vdd_ov_cmp = 1'b0; tick(F - 1);
    rc_strobe = 1'b1; rc_sel = 2'b01;
    tick(1);
    check("R8 refused at boundary", flags, 2'b01);
    tick(1);
    check("R8 accepted after boundary", flags, 2'b00);
    rc_strobe = 1'b0; rc_sel = 2'b00;
    tick(1);
    check("R7 slew back to cfg", drive_slew, 3'b001);

    // R8/R4: one strobe clears one flag and refuses the other; select masking.
    vdd_ov_cmp = 1'b1; dio_ov_cmp[6] = 1'b1; tick(F + 2);
    check("R4 both flags", flags, 2'b11);
    vdd_ov_cmp = 1'b0; tick(F + 1);
    strobe(2'b11);
    check("R8 split clear", flags, 2'b10);
    check("R9 split readback", rc_data, 2'b11);
    dio_ov_cmp = '0; tick(F + 1);
    strobe(2'b01);
    check("R8 unselected untouched", flags, 2'b10);
    check("R9 masked readback", rc_data, 2'b00);
    strobe(2'b10);
    check("R8 selected cleared", flags, 2'b00);
    check("R9 readback dio", rc_data, 2'b10);

    // R1: standby clears a set flag and filter progress.
    vdd_ov_cmp = 1'b1; tick(F + 2);
    standby = 1'b1; tick(1); standby = 1'b0;
    check("R1 standby clears flag", flags, 2'b00);
    check("R1 standby clears force", force_sink, 1'b0);
    tick(3);
    check("R1 run restarted", flags, 2'b00);
    tick(3);
    check("R1 R2 set after restart", flags, 2'b01);
    vdd_ov_cmp = 1'b0; tick(F + 1);
    strobe(2'b01);
    check("R8 final clear", flags, 2'b00);

    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end
endmodule